// File: doc/BRIEF.md
# Transmit Frame Assembly Buffer

This block is the transmit side of an Ethernet MAC as software sees it. Software hands over a frame one 32-bit word at a time through a data write strobe. The block lays each word into a byte store, least significant byte first. The first word of a frame carries the payload length in its low half. The block tracks how many bytes it holds, works out when the frame is fully present, and compares the fill against a programmable threshold. When both conditions hold on a data write, it starts sending without further help. Software may also force a send with an explicit command.

A send streams the frame out on a ready/valid byte port and flags the final byte. The two length bytes are skipped, and any trailing check bytes software left in the store are dropped. Short frames are zero-padded when padding is enabled. When the send ends, the buffer is empty again and a one-cycle transmit-empty pulse is raised. A length that is too large is refused with a one-cycle transmit-error pulse. Acknowledging that error also empties the buffer.

Top module: `tx_asm_fifo`

## Requirements
- R1: When the buffer is empty, bits 15:0 of a written word are the payload length. A length above 2032 causes the word to be discarded, leaves the buffer empty, and raises `txerr_o` for one cycle in the following clock cycle.
- R2: An accepted word is stored as four bytes, bits 7:0 at the lowest address. It is stored only when the fill plus 4 does not exceed 2048 bytes. Otherwise it is dropped.
- R3: A frame counts as complete once the fill reaches payload length + 16 bytes. When `crc_auto_i` is 0, the frame needs 4 more bytes. The amount needed is capped at 2048.
- R4: The threshold is met when the 6-bit threshold value is not 63 and the fill is at least 32 × threshold + 4 bytes. After reset the threshold is 63, so automatic sending is off.
- R5: A data write starts a send in the same clock edge only when both the threshold and completion conditions hold for the fill after that write. `tx_valid_o` is high from the next cycle.
- R6: A write on `cmd_we_i` with `cmd_go_i`=1 forces a send. If the buffer is empty, no byte is sent and `txemp_o` pulses in the following cycle.
- R7: The frame sent is store bytes 2 through payload length + 15, which is payload length + 14 bytes. The length field and any bytes beyond it are not sent.
- R8: With `pad_en_i`=1 at the start of a send, a frame shorter than 60 bytes is extended to 60 bytes with zero bytes. A sent frame is never longer than 2046 bytes.
- R9: After the final byte is accepted, the fill is zero and `txemp_o` pulses for one cycle in the following cycle.
- R10: `err_ack_i` empties the buffer, so the next written word is taken as a new length.
- R11: While a frame is streaming, data writes are ignored and do not alter the frame. `tx_valid_o` and `tx_data_o` hold while `tx_ready_i` is low. `tx_last_o` is high exactly on the final byte.
- R12: After reset, `tx_valid_o`, `txemp_o` and `txerr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_we_i | input | 1 | Data word write strobe |
| data_i | input | 32 | Data word |
| crc_auto_i | input | 1 | 1: check bytes appended downstream, not held in the store |
| pad_en_i | input | 1 | Pad short frames to 60 bytes |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_i | input | 6 | Threshold value |
| cmd_we_i | input | 1 | Transmit command write strobe |
| cmd_go_i | input | 1 | Bit 0 of the command word: force send |
| err_ack_i | input | 1 | Transmit-error acknowledge, empties the buffer |
| tx_ready_i | input | 1 | Sink accepts a byte |
| tx_valid_o | output | 1 | Byte available |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of the frame |
| txemp_o | output | 1 | Transmit-empty pulse |
| txerr_o | output | 1 | Transmit-error pulse |

## Verification
The assertions assume that software treats the block as busy while `tx_valid_o` is high, and that a forced send is issued only when the buffer holds a complete frame or nothing at all. Under that assumption the store bytes read out are always bytes that were written. They also assume that `tx_ready_i` changes only between clock edges. The stimulus follows these rules. Each random frame is written word by word up to exactly its completion point, then either sent by the threshold or forced. Writes made during streaming, overflow words and overlong lengths are aimed only at cases whose outcome the requirements define.

// File: rtl/tx_asm_pkg.sv
package tx_asm_pkg;
  localparam int unsigned LEN_BYTES = 2;
  localparam int unsigned HDR_BYTES = 14;
  localparam int unsigned CRC_BYTES = 4;
  localparam int unsigned MIN_FRAME = 60;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } stream_state_e;
endpackage

// File: rtl/tx_asm_store.sv
module tx_asm_store #(
  parameter int DEPTH = 2048,
  localparam int FILL_W = $clog2(DEPTH) + 1,
  localparam int WORDS = DEPTH / 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [FILL_W-1:0] rd_off_i,
  output logic [7:0]        rd_byte_o
);
  logic [31:0] mem_q [WORDS];
  logic [31:0] rd_word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_comb begin
    rd_word   = mem_q[rd_off_i[AW+1:2]];
    rd_byte_o = rd_word[{rd_off_i[1:0], 3'b000} +: 8];
  end
endmodule

// File: rtl/tx_asm_ctrl.sv
module tx_asm_ctrl
  import tx_asm_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int MAX_LEN = 2032,
  parameter int THR_W = 6,
  localparam int FILL_W = $clog2(DEPTH) + 1,
  localparam int AW = $clog2(DEPTH / 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic [31:0]       data_i,
  input  logic              crc_auto_i,
  input  logic              thr_we_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              cmd_we_i,
  input  logic              cmd_go_i,
  input  logic              err_ack_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              start_o,
  output logic [15:0]       start_len_o,
  output logic              txemp_o,
  output logic              txerr_o
);
  logic [FILL_W-1:0] fill_q, fill_nxt;
  logic [15:0]       len_q, len_cur;
  logic [THR_W-1:0]  thr_q;
  logic              txemp_q, txerr_q;
  logic              first, accept, too_long, room, store;
  logic [16:0]       need, thr_bytes;
  logic              complete, thr_ok, auto_go, force_go;

  always_comb begin
    first    = (fill_q == '0);
    accept   = data_we_i && !busy_i;
    too_long = accept && first && (data_i[15:0] > 16'(MAX_LEN));
    room     = (17'(fill_q) + 17'd4) <= 17'(DEPTH);
    store    = accept && !too_long && room;
    fill_nxt = store ? fill_q + FILL_W'(4) : fill_q;
    len_cur  = (first && store) ? data_i[15:0] : len_q;
    // bytes required before the frame counts as present
    need = 17'(len_cur) + 17'(LEN_BYTES + HDR_BYTES) + (crc_auto_i ? 17'd0 : 17'(CRC_BYTES));
    if (need > 17'(DEPTH)) need = 17'(DEPTH);
    complete  = (fill_nxt != '0) && (17'(fill_nxt) >= need);
    thr_bytes = (17'(thr_q) << 5) + 17'd4;
    thr_ok    = (thr_q != '1) && (17'(fill_nxt) >= thr_bytes);
    auto_go   = accept && !too_long && thr_ok && complete;
    force_go  = cmd_we_i && cmd_go_i && !busy_i;
    start_o     = auto_go || (force_go && !first);
    start_len_o = auto_go ? len_cur : len_q;
    mem_we_o    = store;
    mem_waddr_o = fill_q[AW+1:2];
    mem_wdata_o = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      len_q   <= '0;
      thr_q   <= '1;
      txemp_q <= 1'b0;
      txerr_q <= 1'b0;
    end else begin
      if (err_ack_i || done_i) fill_q <= '0;
      else                     fill_q <= fill_nxt;
      if (first && store) len_q <= data_i[15:0];
      if (thr_we_i) thr_q <= thr_i;
      txerr_q <= too_long;
      txemp_q <= done_i || (force_go && first && !auto_go);
    end
  end

  assign txemp_o = txemp_q;
  assign txerr_o = txerr_q;

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(DEPTH)); // R2
  AST_FILL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q[1:0] == 2'b00); // R2
  AST_ERR_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txerr_q |-> fill_q == '0); // R1
  AST_SEND_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> fill_q == '0); // R9
  AST_ACK_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ack_i |=> fill_q == '0); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_we_i && !err_ack_i && !done_i) |=> fill_q == $past(fill_q)); // R11
endmodule

// File: rtl/tx_asm_stream.sv
module tx_asm_stream
  import tx_asm_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int FILL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       start_len_i,
  input  logic              pad_en_i,
  input  logic [7:0]        rd_byte_i,
  output logic [FILL_W-1:0] rd_off_o,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              busy_o,
  output logic              done_o
);
  stream_state_e     state_q;
  logic [FILL_W-1:0] cnt_q, total_q;
  logic [16:0]       body_q, body, tot;

  always_comb begin
    body = 17'(start_len_i) + 17'(HDR_BYTES);
    tot  = (pad_en_i && body < 17'(MIN_FRAME)) ? 17'(MIN_FRAME) : body;
    if (tot > 17'(DEPTH - LEN_BYTES)) tot = 17'(DEPTH - LEN_BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      total_q <= '0;
      body_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEND;
          cnt_q   <= '0;
          total_q <= tot[FILL_W-1:0];
          body_q  <= body;
        end
        ST_SEND: if (tx_ready_i) begin
          if (tx_last_o) state_q <= ST_IDLE;
          cnt_q <= cnt_q + FILL_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o     = (state_q == ST_SEND);
    tx_valid_o = busy_o;
    tx_last_o  = busy_o && (cnt_q == total_q - FILL_W'(1));
    done_o     = tx_last_o && tx_ready_i;
    rd_off_o   = cnt_q + FILL_W'(LEN_BYTES);
    // bytes past the body are padding
    tx_data_o  = (17'(cnt_q) >= body_q) ? 8'h00 : rd_byte_i;
  end

  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> total_q <= FILL_W'(DEPTH - LEN_BYTES)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < total_q); // R11
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o && $stable(tx_data_o)); // R11
endmodule

// File: rtl/tx_asm_fifo.sv
module tx_asm_fifo #(
  parameter int DEPTH_BYTES = 2048,
  parameter int MAX_LEN = 2032,
  parameter int THR_W = 6,
  localparam int FILL_W = $clog2(DEPTH_BYTES) + 1,
  localparam int AW = $clog2(DEPTH_BYTES / 4)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_we_i,
  input  logic [31:0]      data_i,
  input  logic             crc_auto_i,
  input  logic             pad_en_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             cmd_we_i,
  input  logic             cmd_go_i,
  input  logic             err_ack_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  output logic             txemp_o,
  output logic             txerr_o
);
  logic              mem_we, start, busy, done;
  logic [AW-1:0]     mem_waddr;
  logic [31:0]       mem_wdata;
  logic [15:0]       start_len;
  logic [FILL_W-1:0] rd_off;
  logic [7:0]        rd_byte;

  tx_asm_ctrl #(.DEPTH(DEPTH_BYTES), .MAX_LEN(MAX_LEN), .THR_W(THR_W)) u_ctrl (
    .clk_i, .rst_ni, .data_we_i, .data_i, .crc_auto_i, .thr_we_i, .thr_i,
    .cmd_we_i, .cmd_go_i, .err_ack_i,
    .busy_i(busy), .done_i(done),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .start_o(start), .start_len_o(start_len),
    .txemp_o, .txerr_o
  );

  tx_asm_store #(.DEPTH(DEPTH_BYTES)) u_store (
    .clk_i, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .rd_off_i(rd_off), .rd_byte_o(rd_byte)
  );

  tx_asm_stream #(.DEPTH(DEPTH_BYTES)) u_stream (
    .clk_i, .rst_ni, .start_i(start), .start_len_i(start_len), .pad_en_i,
    .rd_byte_i(rd_byte), .rd_off_o(rd_off), .tx_ready_i,
    .tx_valid_o, .tx_data_o, .tx_last_o, .busy_o(busy), .done_o(done)
  );

  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o); // R11
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !done) |=> tx_valid_o); // R11
endmodule

// File: tb/tb_tx_asm_fifo.sv
module tb_tx_asm_fifo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic data_we = 0, crc_auto = 0, pad_en = 0, thr_we = 0, cmd_we = 0, cmd_go = 0, err_ack = 0;
  logic tx_ready = 0, rdy_en = 0;
  logic [31:0] data = '0;
  logic [5:0] thr = '0;
  logic tx_valid, tx_last, txemp, txerr;
  logic [7:0] tx_data;
  int n_chk = 0, n_fail = 0;
  logic [7:0] store_m [2048];
  logic [7:0] got [2100];

  always #5 clk = ~clk;

  tx_asm_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .data_we_i(data_we), .data_i(data),
    .crc_auto_i(crc_auto), .pad_en_i(pad_en), .thr_we_i(thr_we), .thr_i(thr),
    .cmd_we_i(cmd_we), .cmd_go_i(cmd_go), .err_ack_i(err_ack),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .txemp_o(txemp), .txerr_o(txerr)
  );

  always @(posedge clk) begin
    #2;
    tx_ready = rdy_en && ($urandom_range(3) != 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_need(input int len, input bit crc);
    int n = len + 16 + (crc ? 0 : 4);
    return (n > 2048) ? 2048 : n;
  endfunction

  function automatic int exp_len(input int len, input bit pad);
    int n = len + 14;
    if (pad && n < 60) n = 60;
    return (n > 2046) ? 2046 : n;
  endfunction

  task automatic wr_word(input logic [31:0] w);
    @(negedge clk);
    data_we = 1'b1;
    data = w;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic set_thr(input int t);
    @(negedge clk);
    thr_we = 1'b1;
    thr = 6'(t);
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic force_send();
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    cmd_go = 1'b0;
  endtask

  // collect one frame and compare against the model
  task automatic collect(input int elen, input int len, input string tag);
    int n = 0, bad = -1, guard = 0;
    bit last_ok = 1'b1;
    rdy_en = 1'b1;
    while (guard < 20000) begin
      @(negedge clk);
      guard++;
      if (tx_valid && tx_ready) begin
        got[n] = tx_data;
        if (tx_last != (n == elen - 1)) last_ok = 1'b0;
        n++;
        if (tx_last || n >= 2100) break;
      end
    end
    rdy_en = 1'b0;
    @(negedge clk);
    check(txemp === 1'b1, {tag, " R9 txemp after frame"}, int'(txemp), 1);
    check(n == elen, {tag, " R7 R8 frame length"}, n, elen);
    check(last_ok, {tag, " R11 last on final byte"}, int'(last_ok), 1);
    for (int i = 0; i < n && i < elen; i++) begin
      logic [7:0] e = (i < len + 14) ? store_m[i + 2] : 8'h00;
      if (got[i] !== e && bad < 0) bad = i;
    end
    check(bad < 0, {tag, " R7 R8 frame bytes"}, bad, -1);
    @(negedge clk);
    check(txemp === 1'b0, {tag, " R9 txemp one cycle"}, int'(txemp), 0);
  endtask

  task automatic send_frame(input int len, input bit crc, input bit pad, input int t,
                            input bit extra, input string tag);
    int need, nw, elen;
    bit auto_s;
    crc_auto = crc;
    pad_en = pad;
    set_thr(t);
    need = exp_need(len, crc);
    nw = (need + 3) / 4;
    store_m[0] = 8'(len);
    store_m[1] = 8'(len >> 8);
    for (int i = 2; i < 2048; i++) store_m[i] = 8'($urandom);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      data_we = 1'b1;
      data = {store_m[4*w+3], store_m[4*w+2], store_m[4*w+1], store_m[4*w]};
    end
    if (extra) begin
      @(negedge clk);
      data = $urandom;
    end
    @(negedge clk);
    data_we = 1'b0;
    auto_s = (t != 63) && (32 * t + 4 <= 4 * nw);
    check(tx_valid == auto_s, {tag, " R3 R4 R5 auto start"}, int'(tx_valid), int'(auto_s));
    if (!auto_s) force_send();
    elen = exp_len(len, pad);
    collect(elen, len, tag);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(tx_valid === 1'b0, "R12 valid after reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid === 1'b0 && txemp === 1'b0 && txerr === 1'b0,
          "R12 outputs idle", int'({tx_valid, txemp, txerr}), 0);

    // R4: reset threshold disables auto send
    crc_auto = 1'b1;
    store_m[0] = 8'd0; store_m[1] = 8'd0;
    for (int w = 0; w < 4; w++) wr_word(w == 0 ? 32'hA5A5_0000 : $urandom);
    check(tx_valid === 1'b0, "R4 reset threshold no auto send", int'(tx_valid), 0);
    @(negedge clk); err_ack = 1'b1; @(negedge clk); err_ack = 1'b0;

    // R6: forced send on empty buffer
    force_send();
    check(txemp === 1'b1 && tx_valid === 1'b0, "R6 empty force send",
          int'({txemp, tx_valid}), 2);

    // R1: overlong length refused
    @(negedge clk); data_we = 1'b1; data = 32'h1234_07F1;
    @(negedge clk); data_we = 1'b0;
    check(txerr === 1'b1, "R1 txerr on 2033", int'(txerr), 1);
    check(tx_valid === 1'b0, "R1 no send after refusal", int'(tx_valid), 0);
    @(negedge clk);
    check(txerr === 1'b0, "R1 txerr one cycle", int'(txerr), 0);
    send_frame(30, 1'b1, 1'b0, 0, 1'b0, "R1 after refusal");

    // R10: acknowledge flushes a partial frame
    wr_word(32'h0000_0014); wr_word($urandom); wr_word($urandom);
    @(negedge clk); err_ack = 1'b1; @(negedge clk); err_ack = 1'b0;
    send_frame(20, 1'b0, 1'b0, 0, 1'b0, "R10 after flush");

    // R8: pad boundaries
    send_frame(45, 1'b1, 1'b1, 0, 1'b0, "R8 pad 59");
    send_frame(46, 1'b1, 1'b1, 0, 1'b0, "R8 no pad 60");
    send_frame(0, 1'b0, 1'b1, 63, 1'b0, "R8 pad zero payload");
    send_frame(10, 1'b1, 1'b0, 0, 1'b0, "R7 short unpadded");

    // R4: threshold above final fill needs a forced send
    send_frame(40, 1'b1, 1'b0, 5, 1'b0, "R4 high threshold");
    send_frame(40, 1'b1, 1'b0, 1, 1'b0, "R4 low threshold");

    // R11: word written while streaming is ignored
    send_frame(50, 1'b1, 1'b0, 0, 1'b1, "R11 write during stream");
    force_send();
    check(txemp === 1'b1 && tx_valid === 1'b0, "R11 buffer empty after stream",
          int'({txemp, tx_valid}), 2);

    // R2 R3: largest payload, check bytes held, capped need, overflow word dropped
    send_frame(2032, 1'b0, 1'b0, 63, 1'b1, "R2 R3 full store forced");
    send_frame(2032, 1'b1, 1'b0, 0, 1'b0, "R3 full auto crc");

    for (int k = 0; k < 24; k++) begin
      int sel = $urandom_range(2);
      int t = (sel == 0) ? 0 : (sel == 1) ? 63 : $urandom_range(12);
      send_frame($urandom_range(200), 1'($urandom), 1'($urandom), t, 1'b0, "R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule